// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

This block is a chain of small synchronous up-counter stages, four bits each by default. The stages share one clock, one active-low clear, one active-low parallel load and one count-permit input. The whole chain behaves as a single wide binary counter. Each stage has two count enables. One is a permit input shared by every stage. The other is a chain enable that comes from the previous stage's terminal-count output, so no extra gating is needed between stages.

A build-time parameter selects how clear acts. In one mode it acts asynchronously: a low clear zeroes the count at once. In the other mode it acts synchronously: a low clear is taken only on a rising clock edge. Load sits below clear in priority, and it overrides both enables. The terminal-count output is combinational. It is raised only when the chain enable is high and every count bit is one.

Top module: `casc_counter`

## Requirements
- R1: Apart from an asynchronous clear, the count changes only on a rising clock edge. Input changes between edges leave the count unchanged.
- R2: With ASYNC_CLR=1, a low on `clrN` drives the count to zero immediately, with no clock edge. The count stays zero after `clrN` is released.
- R3: With ASYNC_CLR=0, a low on `clrN` zeroes the count only at the next rising edge. A pulse on `clrN` that is released before any edge has no effect.
- R4: Clear has the highest priority. While `clrN` is low, the count goes to zero whatever `loadN`, `enP`, `enT` and `dIn` are.
- R5: When `clrN` is high and `loadN` is low, the next rising edge copies `dIn` into `q`, whatever the enables are.
- R6: When `clrN` and `loadN` are high and `enP` and `enT` are both high, each rising edge adds one to `q`. Bit 0 of `q` is the least significant bit. From all ones, the count wraps to zero.
- R7: When `clrN` and `loadN` are high and either `enP` or `enT` is low, `q` holds its value.
- R8: `carryOut` is high exactly when `enT` is high and every bit of `q` is one. This holds even when `enP` is low. It follows `enT` within the same cycle, with no clock edge.
- R9: Stage 0 takes its chain enable from `enT`. Each later stage takes it from the previous stage's terminal count. `carryOut` is the last stage's terminal count. Counting therefore carries across stage boundaries as in one binary counter of width STAGES*STAGE_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clrN | input | 1 | Active-low clear, asynchronous or synchronous by parameter |
| loadN | input | 1 | Active-low synchronous parallel load |
| enP | input | 1 | Count permit, shared by all stages |
| enT | input | 1 | Chain enable into stage 0; also gates `carryOut` |
| dIn | input | STAGES*STAGE_W | Parallel load value |
| q | output | STAGES*STAGE_W | Count value, bit 0 least significant |
| carryOut | output | 1 | Terminal count of the whole chain |

## Verification
A load, a count step or a hold appears in `q` one rising edge after the inputs that request it. The bench therefore drives inputs 1 ns after an edge and compares against its own next-value model 1 ns after the following edge. Checks for `carryOut` and for the asynchronous clear come 1 ns after the input change, with no edge in between, because both are due in the same cycle. One synchronous-clear instance and one asynchronous-clear instance receive the same stimulus. A clear pulse placed wholly between two edges must zero only the asynchronous instance. The synchronous instance must hold its value until a clear that is still low at an edge.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  typedef struct packed {
    logic clr;
    logic load;
    logic inc;
  } cntStrobes_t;
endpackage

// File: rtl/cnt_ctrl.sv
module cnt_ctrl
  import cnt_pkg::*;
(
  input  logic        clrN,
  input  logic        loadN,
  input  logic        enP,
  input  logic        enT,
  output cntStrobes_t strobes
);
  // Priority: clear, then load, then count.
  always_comb begin
    strobes.clr  = !clrN;
    strobes.load = clrN && !loadN;
    strobes.inc  = clrN && loadN && enP && enT;
  end
endmodule

// File: rtl/cnt_datapath.sv
module cnt_datapath
  import cnt_pkg::*;
#(
  parameter int W         = 4,
  parameter bit ASYNC_CLR = 1'b1
) (
  input  logic         clk,
  input  logic         clrN,
  input  cntStrobes_t  strobes,
  input  logic [W-1:0] dIn,
  input  logic         enT,
  output logic [W-1:0] q,
  output logic         carry
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] qReg;
  logic [W-1:0] nextQ;

  always_comb begin
    nextQ = qReg;
    if (strobes.clr)       nextQ = '0;
    else if (strobes.load) nextQ = dIn;
    else if (strobes.inc)  nextQ = qReg + ONE;
  end

  generate
    if (ASYNC_CLR) begin : g_async
      always_ff @(posedge clk or negedge clrN) begin
        if (!clrN) qReg <= '0;
        else       qReg <= nextQ;
      end

      // R2: a low clear seen at an edge means the count is already zero
      p_async_clr_r2: assert property (@(posedge clk) !clrN |-> q == '0)
        else $error("p_async_clr_r2");
    end else begin : g_sync
      always_ff @(posedge clk) qReg <= nextQ;

      // R3: a low clear at an edge zeroes the count on that edge
      p_sync_clr_r3: assert property (@(posedge clk) !clrN |=> q == '0)
        else $error("p_sync_clr_r3");

      // R7: no load and no count request leaves the count unchanged
      p_hold_r7: assert property (@(posedge clk) disable iff (!clrN)
        (!strobes.load && !strobes.inc) |=> $stable(q))
        else $error("p_hold_r7");
    end
  endgenerate

  assign q     = qReg;
  assign carry = enT & (&qReg);

  // R5: load copies the data inputs
  p_load_r5: assert property (@(posedge clk) disable iff (!clrN)
    strobes.load |=> q == $past(dIn))
    else $error("p_load_r5");

  // R6: count request adds one, wrapping
  p_inc_r6: assert property (@(posedge clk) disable iff (!clrN)
    strobes.inc |=> q == W'($past(q) + ONE))
    else $error("p_inc_r6");
endmodule

// File: rtl/cnt_stage.sv
module cnt_stage
  import cnt_pkg::*;
#(
  parameter int W         = 4,
  parameter bit ASYNC_CLR = 1'b1
) (
  input  logic         clk,
  input  logic         clrN,
  input  logic         loadN,
  input  logic         enP,
  input  logic         enT,
  input  logic [W-1:0] dIn,
  output logic [W-1:0] q,
  output logic         carry
);
  cntStrobes_t strobes;

  cnt_ctrl u_ctrl (
    .clrN    (clrN),
    .loadN   (loadN),
    .enP     (enP),
    .enT     (enT),
    .strobes (strobes)
  );

  cnt_datapath #(.W(W), .ASYNC_CLR(ASYNC_CLR)) u_dp (
    .clk     (clk),
    .clrN    (clrN),
    .strobes (strobes),
    .dIn     (dIn),
    .enT     (enT),
    .q       (q),
    .carry   (carry)
  );
endmodule

// File: rtl/casc_counter.sv
module casc_counter #(
  parameter int STAGES    = 2,
  parameter int STAGE_W   = 4,
  parameter bit ASYNC_CLR = 1'b1
) (
  input  logic                       clk,
  input  logic                       clrN,
  input  logic                       loadN,
  input  logic                       enP,
  input  logic                       enT,
  input  logic [STAGES*STAGE_W-1:0]  dIn,
  output logic [STAGES*STAGE_W-1:0]  q,
  output logic                       carryOut
);
  localparam int TOTAL_W = STAGES * STAGE_W;

  logic [STAGES:0] chainEn;

  assign chainEn[0] = enT;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      cnt_stage #(.W(STAGE_W), .ASYNC_CLR(ASYNC_CLR)) u_stage (
        .clk   (clk),
        .clrN  (clrN),
        .loadN (loadN),
        .enP   (enP),
        .enT   (chainEn[i]),
        .dIn   (dIn[i*STAGE_W +: STAGE_W]),
        .q     (q[i*STAGE_W +: STAGE_W]),
        .carry (chainEn[i+1])
      );
    end
  endgenerate

  assign carryOut = chainEn[STAGES];

  // R9: the chain increments as one wide counter
  p_wide_count_r9: assert property (@(posedge clk) disable iff (!clrN)
    (loadN && enP && enT) |=> q == TOTAL_W'($past(q) + TOTAL_W'(1)))
    else $error("p_wide_count_r9");

  // R8: the chain's terminal count implies the full count is all ones
  p_chain_carry_r8: assert property (@(posedge clk) disable iff (!clrN)
    carryOut |-> (q == '1))
    else $error("p_chain_carry_r8");
endmodule

// File: tb/casc_counter_tb_top.sv
module casc_counter_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       clrN = 1'b1, loadN = 1'b1, enP = 1'b0, enT = 1'b0;
  logic [7:0] dIn = '0;
  logic [7:0] qA, qS;
  logic       cA, cS;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [7:0] expA, expS;

  casc_counter #(.STAGES(2), .STAGE_W(4), .ASYNC_CLR(1'b1)) dut_i (
    .clk(clk), .clrN(clrN), .loadN(loadN), .enP(enP), .enT(enT),
    .dIn(dIn), .q(qA), .carryOut(cA));

  casc_counter #(.STAGES(2), .STAGE_W(4), .ASYNC_CLR(1'b0)) dut_sync_i (
    .clk(clk), .clrN(clrN), .loadN(loadN), .enP(enP), .enT(enT),
    .dIn(dIn), .q(qS), .carryOut(cS));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] nxt(logic [7:0] cur);
    if (!clrN) return 8'h00;
    if (!loadN) return dIn;
    if (enP && enT) return cur + 8'h01;
    return cur;
  endfunction

  task automatic tick();
    logic [7:0] na, ns;
    na = nxt(expA);
    ns = nxt(expS);
    @(posedge clk);
    #1;
    expA = na;
    expS = ns;
  endtask

  task automatic checkBoth(string req);
    chk(req, qA, expA);
    chk(req, qS, expS);
    chk(req, cA, enT && expA == 8'hFF);
    chk(req, cS, enT && expS == 8'hFF);
  endtask

  task automatic loadVal(logic [7:0] v);
    dIn = v; loadN = 1'b0; enP = 1'b0; enT = 1'b0;
    tick();
    loadN = 1'b1;
  endtask

  task automatic t_reset();
    #1;
    clrN = 1'b0; loadN = 1'b0; enP = 1'b1; enT = 1'b1; dIn = 8'h5A;
    #1;
    chk("R2 async clear without edge", qA, 8'h00);
    tick();
    tick();
    checkBoth("R4 clear over load and enables");
    clrN = 1'b1; loadN = 1'b1; enP = 1'b0; enT = 1'b0;
  endtask

  task automatic t_load();
    dIn = 8'hA5; loadN = 1'b0; enP = 1'b0; enT = 1'b0;
    #1;
    chk("R1 no change between edges", qA, expA);
    chk("R1 no change between edges", qS, expS);
    tick();
    checkBoth("R5 load with enables off");
    dIn = 8'h3C; enP = 1'b1; enT = 1'b1;
    tick();
    checkBoth("R5 load overrides count");
    loadN = 1'b1; enP = 1'b0; enT = 1'b0;
  endtask

  task automatic t_count();
    loadVal(8'h0D);
    enP = 1'b1; enT = 1'b1;
    for (int i = 0; i < 5; i++) begin
      tick();
      checkBoth("R9 carry across stages");
    end
    loadVal(8'hFD);
    enP = 1'b1; enT = 1'b1;
    for (int i = 0; i < 3; i++) begin
      tick();
      checkBoth("R6 count and wrap");
    end
    enP = 1'b0; enT = 1'b0;
  endtask

  task automatic t_hold();
    loadVal(8'h6E);
    enP = 1'b0; enT = 1'b1;
    tick(); checkBoth("R7 hold with enP low");
    tick(); checkBoth("R7 hold with enP low");
    enP = 1'b1; enT = 1'b0;
    tick(); checkBoth("R7 hold with enT low");
    enP = 1'b0;
  endtask

  task automatic t_carry();
    loadVal(8'hFF);
    enP = 1'b0; enT = 1'b1;
    #1;
    chk("R8 carry with enP low", cA, 1'b1);
    chk("R8 carry with enP low", cS, 1'b1);
    enT = 1'b0;
    #1;
    chk("R8 carry follows enT", cA, 1'b0);
    chk("R8 carry follows enT", cS, 1'b0);
    enT = 1'b1;
    #1;
    chk("R8 carry follows enT", cA, 1'b1);
    enT = 1'b0;
    loadVal(8'h0F);
    enT = 1'b1;
    #1;
    chk("R9 carry needs upper stage full", cA, 1'b0);
    chk("R9 carry needs upper stage full", qA, 8'h0F);
    enT = 1'b0;
  endtask

  task automatic t_clear_glitch();
    loadVal(8'h37);
    tick();
    #2;
    clrN = 1'b0;
    #1;
    chk("R2 async clear between edges", qA, 8'h00);
    chk("R3 sync clear waits for edge", qS, 8'h37);
    clrN = 1'b1;
    expA = 8'h00;
    tick();
    chk("R3 released pulse ignored", qS, 8'h37);
    chk("R2 async clear stays zero", qA, 8'h00);
    loadVal(8'h37);
    clrN = 1'b0;
    #1;
    chk("R3 sync clear not before edge", qS, 8'h37);
    tick();
    checkBoth("R3 sync clear at edge");
    clrN = 1'b1;
  endtask

  initial begin
    t_reset();
    t_load();
    t_count();
    t_hold();
    t_carry();
    t_clear_glitch();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule